// File: doc/BRIEF.md
# Word Data Memory with Memory-Mapped I/O Port

This block is the load/store memory of a small processor core. It holds a RAM of 32-bit words addressed with byte addresses, and it sets aside the highest word address, 0xFFFFFFFC, for one input port and one output port. All accesses are full 32-bit words.

A load from any other address returns the RAM word right away, with no clock edge in between. A load from the reserved address returns the live value of the external input bus. A store to an ordinary address writes the RAM on the rising clock edge. A store to the reserved address writes a register that drives the external output bus. That register keeps its value until the next store to the reserved address, and it is cleared by reset.

The RAM index is taken from the address bits just above the two byte-offset bits. The number of index bits comes from the depth parameter, so address bits above the index are not used to select a RAM word.

Top module: `dmem_io`

## Requirements
- R1: While rst_n is low, io_out is zero from the next rising clock edge on.
- R2: When wr_en is high and addr is not 0xFFFFFFFC, the RAM word selected by addr[IDX_W+1:2] takes wr_data at the rising clock edge. IDX_W is clog2(DEPTH).
- R3: Reads are combinational. For an addr other than 0xFFFFFFFC, rd_data shows the selected RAM word in the same cycle, with no clock edge needed.
- R4: addr[1:0] has no effect on which RAM word is read or written.
- R5: When addr equals 0xFFFFFFFC, rd_data equals io_in in the same cycle and follows any change of io_in.
- R6: A store with wr_en high to 0xFFFFFFFC loads wr_data into io_out at that rising edge.
- R7: In any cycle without a store to 0xFFFFFFFC, io_out keeps its value. This includes RAM stores and cycles with wr_en low.
- R8: A store to 0xFFFFFFFC does not change any RAM word. This includes the word that its index bits would select, DEPTH-1.
- R9: With wr_en low, no RAM word changes, whatever addr and wr_data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stores happen on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset for the output port |
| wr_en | input | 1 | Store enable |
| addr | input | 32 | Byte address of the word access |
| wr_data | input | 32 | Store data |
| rd_data | output | 32 | Load data (RAM word or io_in) |
| io_in | input | 32 | External input port, read at 0xFFFFFFFC |
| io_out | output | 32 | Registered external output port, written at 0xFFFFFFFC |

## Verification
Load results are combinational, so the bench changes addr or io_in and samples rd_data 1 ns later, with no clock edge in between. Store results are due at the first rising edge after wr_en is raised. Inputs change on the falling edge, and RAM read-back and io_out are sampled at the following falling edge, which is exactly one edge later. For the hold and no-effect cases, the bench samples io_out or reads back the RAM word before any other store takes place.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] IO_ADDR = 32'hFFFF_FFFC;

  typedef struct packed {
    logic io_hit;
    logic ram_we;
    logic port_we;
  } dmem_sel_t;

  // Full-width compare so every address bit takes part in the I/O decode
  function automatic logic io_match(input logic [ADDR_W-1:0] a);
    return a == IO_ADDR;
  endfunction

  function automatic dmem_sel_t classify(input logic [ADDR_W-1:0] a,
                                         input logic we);
    dmem_sel_t s;
    s.io_hit  = io_match(a);
    s.ram_we  = we & ~s.io_hit;
    s.port_we = we & s.io_hit;
    return s;
  endfunction
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output dmem_sel_t         sel,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    sel = classify(addr, wr_en);
    idx = addr[IDX_W+1:2];
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/dmem_outport.sv
module dmem_outport #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/dmem_io.sv
module dmem_io
  import dmem_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] io_in,
  output logic [DATA_W-1:0] io_out
);
  dmem_sel_t         sel;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] ram_rd;
  // Named events for the checker
  logic io_hit, ram_we, port_we;

  dmem_decode #(.IDX_W(IDX_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .sel(sel), .idx(idx)
  );

  assign io_hit  = sel.io_hit;
  assign ram_we  = sel.ram_we;
  assign port_we = sel.port_we;

  dmem_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .idx(idx), .wdata(wr_data), .rdata(ram_rd)
  );

  dmem_outport #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n), .we(port_we), .d(wr_data), .q(io_out)
  );

  assign rd_data = io_hit ? io_in : ram_rd;
endmodule

// File: rtl/dmem_io_checker.sv
module dmem_io_checker
  import dmem_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] io_in,
  input logic [DATA_W-1:0] io_out,
  input logic              ram_we,
  input logic              port_we
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> io_out == '0);

  a_r5_io_read: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 32'hFFFF_FFFC) |-> rd_data == io_in);

  a_r6_port_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 32'hFFFF_FFFC) |=> io_out == $past(wr_data));

  a_r7_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 32'hFFFF_FFFC) |=> $stable(io_out));

  a_r8_no_ram_on_io: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 32'hFFFF_FFFC) |-> !ram_we);

  a_r9_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !(ram_we || port_we));
endmodule

bind dmem_io dmem_io_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .io_in(io_in), .io_out(io_out),
  .ram_we(ram_we), .port_we(port_we)
);

// File: tb/dmem_io_bench.sv
`timescale 1ns/1ps
module dmem_io_bench;
  localparam int DEPTH = 64;
  localparam logic [31:0] IOA = 32'hFFFF_FFFC;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] addr = 0, wr_data = 0, io_in = 0;
  logic [31:0] rd_data, io_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dmem_io #(.DEPTH(DEPTH)) u_dmem_io (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .io_in(io_in), .io_out(io_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic load(input logic [31:0] a, output logic [31:0] v);
    addr = a; #1; v = rd_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    repeat (2) @(negedge clk);
    check("R1 io_out in reset", io_out, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R1 io_out after reset", io_out, 32'h0);
    v = 0;
  endtask

  task automatic t_ram_rw;
    logic [31:0] v;
    store(32'h0000_0010, 32'hDEAD_BEEF);
    store(32'h0000_0020, 32'h1234_5678);
    load(32'h0000_0010, v); check("R2 word 4 readback", v, 32'hDEAD_BEEF);
    load(32'h0000_0020, v); check("R3 word 8 comb read", v, 32'h1234_5678);
    load(32'h0000_0010, v); check("R3 re-read without edge", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_offset;
    logic [31:0] v;
    store(32'h0000_0033, 32'hA5A5_0001);   // word 12 via offset 3
    load(32'h0000_0030, v); check("R4 offset-3 store, aligned read", v, 32'hA5A5_0001);
    load(32'h0000_0031, v); check("R4 offset-1 read", v, 32'hA5A5_0001);
  endtask

  task automatic t_io_in;
    logic [31:0] v;
    io_in = 32'hCAFE_0001;
    load(IOA, v); check("R5 io_in read", v, 32'hCAFE_0001);
    io_in = 32'h0BAD_F00D; #1;
    check("R5 io_in follows", rd_data, 32'h0BAD_F00D);
  endtask

  task automatic t_io_out;
    store(IOA, 32'h5555_AAAA);
    check("R6 io_out updated", io_out, 32'h5555_AAAA);
    store(IOA, 32'h0000_0077);
    check("R6 io_out second store", io_out, 32'h0000_0077);
  endtask

  task automatic t_io_hold;
    store(32'h0000_0040, 32'h9999_9999);
    check("R7 hold over RAM store", io_out, 32'h0000_0077);
    @(negedge clk); addr = IOA; wr_data = 32'hFFFF_0000; wr_en = 0;
    @(negedge clk);
    check("R7 hold with wr_en low", io_out, 32'h0000_0077);
  endtask

  task automatic t_io_no_ram;
    logic [31:0] v;
    store((DEPTH-1)*4, 32'h7777_1111);
    store(IOA, 32'h2222_3333);
    load((DEPTH-1)*4, v); check("R8 aliased word intact", v, 32'h7777_1111);
  endtask

  task automatic t_wr_en_low;
    logic [31:0] v;
    @(negedge clk); addr = 32'h10; wr_data = 32'h0; wr_en = 0;
    @(negedge clk);
    load(32'h10, v); check("R9 no write with wr_en low", v, 32'hDEAD_BEEF);
  endtask

  initial begin
    t_reset();
    t_ram_rw();
    t_offset();
    t_io_in();
    t_io_out();
    t_io_hold();
    t_io_no_ram();
    t_wr_en_low();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule